// File: doc/BRIEF.md
# Priority Burst DMA Bus Requester

This block drives the bus request for a network controller that has two DMA engines sharing one memory bus. The local engine moves packet data between a FIFO and buffer memory in fixed-length bursts. The remote engine moves single bytes between buffer memory and a host-visible port. The block watches the bus acknowledge input and decides which engine owns each bus cycle. It counts the data cycles of each burst. When 32-bit addressing is enabled, it inserts an upper-address phase at the start of each local burst.

Local service is started when the FIFO fill level rises above a programmed threshold. Local work has priority over remote work. A local need that appears while the remote engine holds the bus keeps the request asserted, and the burst follows the current byte directly. Once local service ends, the request always drops before remote work continues. The remote engine releases the request after every byte, so other masters can win the bus between bytes. A remote operation is loaded with a byte count and a direction. It signals completion with a one-cycle pulse.

Top module: `burst_bus_req`

## Requirements
- R1: After reset, `bus_req` is 0, `owner` is 0, `rmt_busy` is 0 and no strobe or pulse output is high.
- R2: While idle, a local request is started only when `fifo_level` is strictly greater than `fifo_thresh`. Equal or lower levels raise no request.
- R3: A local burst has a fixed number of acknowledged data cycles, each shown on `loc_beat`. With `cfg_word_mode`=1 the codes 0,1,2,3 of `cfg_burst_sel` give 1, 2, 4 and 6 cycles. With `cfg_word_mode`=0 the same codes give 2, 4, 8 and 12. `loc_done` pulses on the last cycle.
- R4: With `cfg_wide32`=1, each local burst begins with exactly 4 acknowledged cycles of `addr_phase`=1. During these cycles `addr_hi` carries `cfg_page_hi`. Otherwise `addr_hi` is 0. These cycles are not counted as data.
- R5: If `bus_ack` is low during an address or data cycle of a local burst, `loc_abort` pulses in that cycle and the request is released in the next cycle.
- R6: When the block is idle with both local demand and remote work pending, the local engine is served first. A local demand that appears while the remote engine is still waiting for acknowledge takes over the request at once.
- R7: If local demand is present in a cycle in which a remote byte is acknowledged, `bus_req` stays high. The local burst starts in the next cycle without waiting for a new acknowledge.
- R8: After `loc_done`, `bus_req` is low for at least one cycle.
- R9: The remote engine moves one byte per acknowledged cycle (`rmt_beat`). It releases `bus_req` for at least one cycle after each byte unless R7 applies.
- R10: A `rmt_start` pulse while not busy and with a nonzero `rmt_len` loads the byte count. Each byte decrements it. `rmt_done` pulses with the last byte and `rmt_busy` then falls. A zero length is ignored.
- R11: `rmt_write` takes the value of `rmt_write_in` at a start that is accepted. A `rmt_start` while busy changes neither the direction nor the count.
- R12: `owner` reads 1 while the local engine holds or requests the bus, 2 while the remote engine does, and 0 when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word_mode | input | 1 | 1 = word transfers, 0 = byte transfers |
| cfg_burst_sel | input | 2 | Burst length code |
| cfg_wide32 | input | 1 | Enables the upper-address phase |
| cfg_page_hi | input | PAGE_W | Upper address (64 KB page) |
| fifo_level | input | LVL_W | Current FIFO fill level |
| fifo_thresh | input | LVL_W | Threshold for local service |
| rmt_start | input | 1 | Start pulse for a remote operation |
| rmt_write_in | input | 1 | Direction at start: 1 port to memory, 0 memory to port |
| rmt_len | input | CNT_W | Remote byte count at start |
| bus_ack | input | 1 | Bus acknowledge |
| bus_req | output | 1 | Bus request |
| owner | output | 2 | Engine owning the bus: 0 none, 1 local, 2 remote |
| addr_phase | output | 1 | Upper-address cycle in progress |
| addr_hi | output | PAGE_W | Upper address during the address phase, else 0 |
| loc_beat | output | 1 | Local data cycle acknowledged |
| loc_done | output | 1 | Last data cycle of a local burst |
| loc_abort | output | 1 | Local burst aborted by loss of acknowledge |
| rmt_beat | output | 1 | Remote byte transferred |
| rmt_done | output | 1 | Last remote byte transferred |
| rmt_busy | output | 1 | Remote bytes still outstanding |
| rmt_write | output | 1 | Direction of the current remote operation |

## Verification
The assertions assume that `cfg_wide32`, `cfg_word_mode` and `cfg_burst_sel` stay unchanged while a request is raised. They also assume that `bus_ack` does not change between clock edges. The stimulus changes configuration only when the block has been idle for many cycles. It drives every input just after the falling edge. Acknowledge normally follows the previous cycle's request, and it is forced low for a single cycle only to provoke an abort.

// File: rtl/burst_bus_req_pkg.sv
package burst_bus_req_pkg;

  localparam int BEATS_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LWAIT = 3'd1,
    ST_LADDR = 3'd2,
    ST_LDATA = 3'd3,
    ST_RMT   = 3'd4
  } st_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_LOC  = 2'd1,
    OWN_RMT  = 2'd2
  } own_e;

  // data cycles per local burst; byte mode doubles the word-mode count
  function automatic logic [BEATS_W-1:0] burst_beats(input logic word, input logic [1:0] sel);
    logic [BEATS_W-1:0] w;
    w = (sel == 2'd3) ? BEATS_W'(6) : (BEATS_W'(1) << sel);
    return word ? w : {w[BEATS_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/bdr_beat_cnt.sv
module bdr_beat_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bdr_rmt_cnt.sv
module bdr_rmt_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_in,
  input  logic [CNT_W-1:0] len,
  input  logic             beat,
  output logic             busy,
  output logic             last,
  output logic             write
);
  logic [CNT_W-1:0] left;
  logic             accept;

  assign accept = start && !busy && (len != '0);
  assign busy   = (left != '0);
  assign last   = (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left  <= '0;
      write <= 1'b0;
    end else if (accept) begin
      left  <= len;
      write <= dir_in;
    end else if (beat && busy) begin
      left  <= left - 1'b1;
    end
  end
endmodule

// File: rtl/bdr_arb.sv
module bdr_arb
  import burst_bus_req_pkg::*;
#(
  parameter int BW       = BEATS_W,
  parameter int ADDR_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loc_want,
  input  logic          rmt_busy,
  input  logic          bus_ack,
  input  logic          wide32,
  input  logic [BW-1:0] beats,
  input  logic [BW-1:0] cnt,
  output st_e           state,
  output logic          cnt_clr,
  output logic          cnt_step,
  output logic          loc_beat,
  output logic          loc_last,
  output logic          loc_abort,
  output logic          rmt_beat
);
  st_e nxt;
  st_e first_ph;

  assign first_ph = wide32 ? ST_LADDR : ST_LDATA;

  always_comb begin
    nxt       = state;
    cnt_clr   = 1'b0;
    cnt_step  = 1'b0;
    loc_beat  = 1'b0;
    loc_last  = 1'b0;
    loc_abort = 1'b0;
    rmt_beat  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (loc_want)      nxt = ST_LWAIT;
        else if (rmt_busy) nxt = ST_RMT;
      end
      ST_LWAIT: begin
        if (bus_ack) begin
          nxt     = first_ph;
          cnt_clr = 1'b1;
        end
      end
      ST_LADDR: begin
        if (!bus_ack) begin
          loc_abort = 1'b1;
          nxt       = ST_IDLE;
        end else if (cnt == BW'(ADDR_CYC - 1)) begin
          nxt     = ST_LDATA;
          cnt_clr = 1'b1;
        end else begin
          cnt_step = 1'b1;
        end
      end
      ST_LDATA: begin
        if (!bus_ack) begin
          loc_abort = 1'b1;
          nxt       = ST_IDLE;
        end else begin
          loc_beat = 1'b1;
          if (cnt == beats - 1'b1) begin
            loc_last = 1'b1;
            nxt      = ST_IDLE;
          end else begin
            cnt_step = 1'b1;
          end
        end
      end
      ST_RMT: begin
        if (bus_ack) begin
          rmt_beat = 1'b1;
          if (loc_want) begin
            nxt     = first_ph;
            cnt_clr = 1'b1;
          end else begin
            nxt = ST_IDLE;
          end
        end else if (loc_want) begin
          nxt = ST_LWAIT;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/burst_bus_req.sv
module burst_bus_req
  import burst_bus_req_pkg::*;
#(
  parameter int LVL_W    = 6,
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 16,
  parameter int ADDR_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_word_mode,
  input  logic [1:0]        cfg_burst_sel,
  input  logic              cfg_wide32,
  input  logic [PAGE_W-1:0] cfg_page_hi,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [LVL_W-1:0]  fifo_thresh,
  input  logic              rmt_start,
  input  logic              rmt_write_in,
  input  logic [CNT_W-1:0]  rmt_len,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic [1:0]        owner,
  output logic              addr_phase,
  output logic [PAGE_W-1:0] addr_hi,
  output logic              loc_beat,
  output logic              loc_done,
  output logic              loc_abort,
  output logic              rmt_beat,
  output logic              rmt_done,
  output logic              rmt_busy,
  output logic              rmt_write
);
  localparam int BW = BEATS_W;

  st_e          state;
  own_e         own;
  logic         loc_want;
  logic [BW-1:0] beats;
  logic [BW-1:0] cnt;
  logic         cnt_clr;
  logic         cnt_step;
  logic         rmt_last;

  assign loc_want = fifo_level > fifo_thresh;
  assign beats    = burst_beats(cfg_word_mode, cfg_burst_sel);

  bdr_arb #(.BW(BW), .ADDR_CYC(ADDR_CYC)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_want  (loc_want),
    .rmt_busy  (rmt_busy),
    .bus_ack   (bus_ack),
    .wide32    (cfg_wide32),
    .beats     (beats),
    .cnt       (cnt),
    .state     (state),
    .cnt_clr   (cnt_clr),
    .cnt_step  (cnt_step),
    .loc_beat  (loc_beat),
    .loc_last  (loc_done),
    .loc_abort (loc_abort),
    .rmt_beat  (rmt_beat)
  );

  bdr_beat_cnt #(.W(BW)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .step  (cnt_step),
    .cnt   (cnt)
  );

  bdr_rmt_cnt #(.CNT_W(CNT_W)) u_rmt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rmt_start),
    .dir_in (rmt_write_in),
    .len    (rmt_len),
    .beat   (rmt_beat),
    .busy   (rmt_busy),
    .last   (rmt_last),
    .write  (rmt_write)
  );

  always_comb begin
    case (state)
      ST_LWAIT, ST_LADDR, ST_LDATA: own = OWN_LOC;
      ST_RMT:                       own = OWN_RMT;
      default:                      own = OWN_NONE;
    endcase
  end

  assign owner      = own;
  assign bus_req    = (state != ST_IDLE);
  assign addr_phase = (state == ST_LADDR);
  assign addr_hi    = addr_phase ? cfg_page_hi : '0;
  assign rmt_done   = rmt_beat && rmt_last;
endmodule

// File: rtl/burst_bus_req_chk.sv
module burst_bus_req_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic [1:0] owner,
  input logic       addr_phase,
  input logic       cfg_wide32,
  input logic       loc_want,
  input logic       loc_done,
  input logic       loc_abort,
  input logic       rmt_beat,
  input logic       rmt_done,
  input logic       rmt_busy,
  input logic       rmt_write
);
  a_r2_no_req_without_need: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && !loc_want && !rmt_busy) |=> !bus_req);

  a_r4_addr_needs_wide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_phase) |-> (cfg_wide32 && owner == 2'd1));

  a_r5_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    loc_abort |=> !bus_req);

  a_r6_local_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && loc_want) |=> (bus_req && owner == 2'd1));

  a_r7_append_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_beat && loc_want) |=> (bus_req && owner == 2'd1));

  a_r8_gap_after_local: assert property (@(posedge clk) disable iff (!rst_n)
    loc_done |=> !bus_req);

  a_r9_byte_release: assert property (@(posedge clk) disable iff (!rst_n)
    (rmt_beat && !loc_want) |=> !bus_req);

  a_r10_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_done |=> !rmt_busy);

  a_r11_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rmt_busy |=> (!rmt_busy || $stable(rmt_write)));

  a_r12_owner_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_done, loc_abort, rmt_done}) && (bus_req == (owner != 2'd0)));
endmodule

bind burst_bus_req burst_bus_req_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .owner      (owner),
  .addr_phase (addr_phase),
  .cfg_wide32 (cfg_wide32),
  .loc_want   (loc_want),
  .loc_done   (loc_done),
  .loc_abort  (loc_abort),
  .rmt_beat   (rmt_beat),
  .rmt_done   (rmt_done),
  .rmt_busy   (rmt_busy),
  .rmt_write  (rmt_write)
);

// File: tb/burst_bus_req_bench.sv
`timescale 1ns/1ps
module burst_bus_req_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_word_mode, cfg_wide32;
  logic [1:0]  cfg_burst_sel;
  logic [15:0] cfg_page_hi;
  logic [5:0]  fifo_level, fifo_thresh;
  logic        rmt_start, rmt_write_in;
  logic [15:0] rmt_len;
  logic        bus_ack;
  logic        bus_req, addr_phase, loc_beat, loc_done, loc_abort;
  logic        rmt_beat, rmt_done, rmt_busy, rmt_write;
  logic [1:0]  owner;
  logic [15:0] addr_hi;

  always #5 clk = ~clk;

  burst_bus_req u_burst_bus_req (.*);

  int checks = 0, fails = 0;
  // behavioural reference: 0 idle, 1 local wait, 2 address, 3 data, 4 remote
  int m_mode = 0, m_addr_left = 0, m_beats_left = 0, m_rmt_left = 0;
  bit m_wr = 0;
  bit auto_ack = 1, force_low = 0, prev_req = 0, last_ldone = 0;
  int req_hi = 0, rdone_seen = 0;
  int len_tbl[8] = '{2, 4, 8, 12, 1, 2, 4, 6};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cur_len();
    return len_tbl[{cfg_word_mode, cfg_burst_sel}];
  endfunction

  task automatic enter_local();
    if (cfg_wide32) begin m_mode = 2; m_addr_left = 4; end
    else begin m_mode = 3; m_beats_left = cur_len(); end
  endtask

  task automatic step();
    bit want, e_req, e_addr, e_lb, e_ld, e_ab, e_rb, e_rd;
    int e_own;
    if (auto_ack) bus_ack = force_low ? 1'b0 : prev_req;
    #1;
    want   = fifo_level > fifo_thresh;
    e_req  = m_mode != 0;
    e_own  = (m_mode == 4) ? 2 : (m_mode != 0 ? 1 : 0);
    e_addr = m_mode == 2;
    e_lb   = m_mode == 3 && bus_ack;
    e_ld   = e_lb && m_beats_left == 1;
    e_ab   = (m_mode == 2 || m_mode == 3) && !bus_ack;
    e_rb   = m_mode == 4 && bus_ack;
    e_rd   = e_rb && m_rmt_left == 1;
    chk(bus_req == e_req, "R2 R6 R7 R9 bus_req", bus_req, e_req);
    chk(owner == e_own, "R12 owner", owner, e_own);
    chk(addr_phase == e_addr, "R4 addr_phase", addr_phase, e_addr);
    chk(addr_hi == (e_addr ? cfg_page_hi : 16'h0), "R4 addr_hi", addr_hi, e_addr ? cfg_page_hi : 0);
    chk(loc_beat == e_lb, "R3 loc_beat", loc_beat, e_lb);
    chk(loc_done == e_ld, "R3 loc_done", loc_done, e_ld);
    chk(loc_abort == e_ab, "R5 loc_abort", loc_abort, e_ab);
    chk(rmt_beat == e_rb, "R9 rmt_beat", rmt_beat, e_rb);
    chk(rmt_done == e_rd, "R10 rmt_done", rmt_done, e_rd);
    chk(rmt_busy == (m_rmt_left > 0), "R10 rmt_busy", rmt_busy, m_rmt_left > 0);
    chk(rmt_write == m_wr, "R11 rmt_write", rmt_write, m_wr);
    if (last_ldone) chk(bus_req == 1'b0, "R8 gap after local", bus_req, 0);
    last_ldone = loc_done;
    prev_req   = bus_req;
    req_hi     += bus_req;
    rdone_seen += rmt_done;
    case (m_mode)
      0: if (want) m_mode = 1; else if (m_rmt_left > 0) m_mode = 4;
      1: if (bus_ack) enter_local();
      2: if (!bus_ack) m_mode = 0;
         else begin
           m_addr_left--;
           if (m_addr_left == 0) begin m_mode = 3; m_beats_left = cur_len(); end
         end
      3: if (!bus_ack) m_mode = 0;
         else begin
           m_beats_left--;
           if (m_beats_left == 0) m_mode = 0;
         end
      4: if (bus_ack) begin
           m_rmt_left--;
           if (want) enter_local(); else m_mode = 0;
         end else if (want) m_mode = 1;
      default: m_mode = 0;
    endcase
    if (rmt_start && m_rmt_left == 0 && rmt_len != 0) begin
      m_rmt_left = rmt_len;
      m_wr = rmt_write_in;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic kick_local();
    fifo_level = fifo_thresh + 1;
    step();
    fifo_level = fifo_thresh;
  endtask

  task automatic pulse_start(input int len, input bit dir);
    rmt_len = len; rmt_write_in = dir; rmt_start = 1;
    step();
    rmt_start = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_word_mode = 0; cfg_wide32 = 0; cfg_burst_sel = 0;
    cfg_page_hi = 16'hBEEF; fifo_level = 8; fifo_thresh = 8;
    rmt_start = 0; rmt_write_in = 0; rmt_len = 0; bus_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(bus_req == 0 && owner == 0 && rmt_busy == 0, "R1 reset outputs", {bus_req, owner, rmt_busy}, 0);
    chk({loc_beat, loc_done, loc_abort, rmt_beat, rmt_done, addr_phase} == 0, "R1 reset strobes", 1, 0);
    @(negedge clk);

    // R2: level equal to threshold raises nothing
    req_hi = 0;
    run(8);
    chk(req_hi == 0, "R2 no request at level==thresh", req_hi, 0);

    // R3: every length code, both modes
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        cfg_word_mode = w[0]; cfg_burst_sel = s[1:0];
        kick_local();
        run(18);
      end

    // R4: upper-address phase
    cfg_wide32 = 1; cfg_word_mode = 0; cfg_burst_sel = 1;
    kick_local(); run(14);
    cfg_page_hi = 16'h1234; cfg_burst_sel = 0;
    kick_local(); run(12);
    cfg_wide32 = 0;

    // R5: abort in the data phase and in the address phase
    cfg_burst_sel = 3;
    kick_local(); run(3);
    force_low = 1; step(); force_low = 0;
    run(6);
    cfg_wide32 = 1;
    kick_local(); run(3);
    force_low = 1; step(); force_low = 0;
    run(6);
    cfg_wide32 = 0; cfg_burst_sel = 1;

    // R10/R11: remote operation, ignored restart, zero length
    rdone_seen = 0;
    pulse_start(0, 1); run(3);
    chk(rmt_busy == 0, "R10 zero length ignored", rmt_busy, 0);
    pulse_start(3, 1); run(14);
    chk(rdone_seen == 1, "R10 one done pulse", rdone_seen, 1);
    pulse_start(4, 0); run(2);
    pulse_start(9, 1);
    chk(rmt_write == 0, "R11 start while busy ignored", rmt_write, 0);
    run(20);
    chk(rdone_seen == 2 && rmt_busy == 0, "R10 count kept after ignored start", rdone_seen, 2);

    // R7: local need during an acknowledged remote byte
    pulse_start(5, 1);
    for (int i = 0; i < 30; i++) begin
      if (m_mode == 4 && prev_req) break;
      step();
    end
    fifo_level = fifo_thresh + 1;
    step();
    fifo_level = fifo_thresh;
    chk(bus_req == 1 && owner == 1, "R7 request held into local burst", {bus_req, owner}, 3'b101);
    run(30);

    // R6: both pending while idle, local first
    pulse_start(3, 0);
    fifo_level = fifo_thresh + 1;
    step();
    fifo_level = fifo_thresh;
    chk(owner == 1, "R6 local wins when both pending", owner, 1);
    run(30);

    // R6: local takes over a remote still waiting for acknowledge
    auto_ack = 0; bus_ack = 0;
    pulse_start(2, 1); run(3);
    chk(owner == 2, "R12 remote owns while waiting", owner, 2);
    fifo_level = fifo_thresh + 1;
    step();
    fifo_level = fifo_thresh;
    chk(owner == 1 && bus_req == 1, "R6 local preempts waiting remote", owner, 1);
    auto_ack = 1;
    run(40);

    finish_run();
  end
endmodule